// File: doc/BRIEF.md
# Three-Phase 64-bit Load-Store Execution Core

This block is a small 64-bit load-store processor core. It runs a subset of a RISC instruction set, and every instruction walks through a fixed sequence of three phases. In fetch, the program counter is presented to a synchronous instruction memory. In execute, the returned 32-bit word is decoded, two registers are read, and either an ALU result or an effective address is formed. In update, the register file or the data memory is written and the program counter moves on by four bytes.

The instruction set has four integer operations: add, subtract-after-scaling-by-four, logical left shift and multiply. Each of them exists in a register-register form and in a register-literal form. There are also 64-bit load and store instructions that use base-plus-displacement addressing. A return-style opcode stops the core. An unknown encoding or a misaligned data access also stops the core, and it raises an error flag. Both memories sit outside the block on plain synchronous ports, and read data arrives one clock after the address.

Field layout: opcode in bits 31:26, first register (a) in 25:21, second register (b) in 20:16. For operates, the literal is in 20:13, the form bit in 12, the function code in 11:5 and the destination in 4:0. For loads and stores, the signed displacement is in 15:0.

Top module: `tri_phase_core`

## Requirements
- R1: While rst is high, halted, illegal, misalign, dmem_we and dmem_re are 0, and imem_addr equals RESET_PC (default 0). This holds even when the core had stopped before the reset.
- R2: Every non-stopping instruction takes exactly three clock cycles, and imem_addr advances by 4 each time. With N such instructions followed by the stop word, halted reads 1 after 3N+2 rising edges counted from reset release.
- R3: Opcode 0x10 with function 0x20 writes a+b to the destination. Opcode 0x10 with function 0x2B writes 4*a-b. Opcode 0x13 with function 0x20 writes the low 64 bits of a*b. All arithmetic is modulo 2^64.
- R4: Opcode 0x12 with function 0x39 writes a shifted left by the low 6 bits of b. For example, b=65 shifts by 1.
- R5: When bit 12 is 1, b is the 8-bit literal in bits 20:13, zero-extended, in place of register b.
- R6: Register 31 reads as zero. Operate results and load data aimed at register 31 are discarded.
- R7: Opcode 0x29 loads the 64-bit word at EA = Reg[b] + sign-extended bits 15:0 into register a. Opcode 0x2D stores register a to the same EA. A store appears as one cycle of dmem_we with dmem_addr=EA and dmem_wdata=Reg[a]. dmem_we and dmem_re are never high together.
- R8: A loaded value is available to the instruction that immediately follows the load.
- R9: A load or store whose EA has a nonzero low three bits makes no memory access and sets misalign and halted. No later instruction executes.
- R10: Any other opcode, or a known operate opcode with an unlisted function, sets illegal and halted. No later instruction executes, and the flags stay set until reset.
- R11: Opcode 0x1A sets halted with illegal and misalign at 0. imem_addr then holds the stop word's address, and no memory strobes occur.
- R12: The words 0x42110401, 0x42410400, 0x42009410, 0x42310571, 0x4a209731, 0x42110410, 0x4c100400 run in order with x, y and z in registers 16, 17 and 18. Afterwards register 0 holds (x+y+z)*((x+4)+48*y).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | XLEN | Byte address of the instruction to fetch (registered) |
| imem_rdata | input | 32 | Instruction word, valid the cycle after imem_addr |
| dmem_addr | output | XLEN | Data byte address (registered) |
| dmem_re | output | 1 | Data read strobe |
| dmem_we | output | 1 | Data write strobe |
| dmem_wdata | output | XLEN | Store data |
| dmem_rdata | input | XLEN | Load data, valid the cycle after dmem_re |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Stopped on an unknown encoding |
| misalign | output | 1 | Stopped on a misaligned data address |

## Verification
The hardest case to reach is a load whose data returns only after the update phase has ended and is then read by the very next instruction. The stimulus reaches it with load-then-use chains in which a loaded pointer is immediately the base of a second load with a negative displacement, and that result then feeds an add. The error stops are driven with store words placed directly after the faulting instruction. Any write that should not happen then shows up as an unexpected item at the data port, where a scoreboard of expected stores catches it.

// File: rtl/tri_phase_pkg.sv
package tri_phase_pkg;

  localparam int IW = 32;

  localparam logic [5:0] OPC_INTA = 6'h10;
  localparam logic [5:0] OPC_SHFT = 6'h12;
  localparam logic [5:0] OPC_MULT = 6'h13;
  localparam logic [5:0] OPC_STOP = 6'h1A;
  localparam logic [5:0] OPC_LDQ  = 6'h29;
  localparam logic [5:0] OPC_STQ  = 6'h2D;

  localparam logic [6:0] FN_ADD   = 7'h20;
  localparam logic [6:0] FN_S4SUB = 7'h2B;
  localparam logic [6:0] FN_SLL   = 7'h39;
  localparam logic [6:0] FN_MUL   = 7'h20;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_S4SUB,
    ALU_SLL,
    ALU_MUL
  } alu_op_e;

  typedef enum logic [2:0] {
    K_OPER,
    K_LOAD,
    K_STORE,
    K_STOP,
    K_BAD
  } ikind_e;

  typedef struct packed {
    ikind_e      kind;
    alu_op_e     aluop;
    logic [4:0]  ra;
    logic [4:0]  rb;
    logic [4:0]  rc;
    logic        use_lit;
    logic [7:0]  lit;
    logic [15:0] disp;
  } dec_t;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_EXEC,
    ST_UPDATE,
    ST_HALT
  } phase_e;

endpackage

// File: rtl/tpc_regfile.sv
module tpc_regfile #(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic [RAW-1:0]  ra_idx,
  input  logic [RAW-1:0]  rb_idx,
  output logic [XLEN-1:0] ra_val,
  output logic [XLEN-1:0] rb_val,
  input  logic            wr_en,
  input  logic [RAW-1:0]  wr_idx,
  input  logic [XLEN-1:0] wr_val
);

  localparam logic [RAW-1:0] ZREG = RAW'(NREG - 1);

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_idx != ZREG)) begin
      regs[wr_idx] <= wr_val;
    end
  end

  assign ra_val = (ra_idx == ZREG) ? '0 : regs[ra_idx];
  assign rb_val = (rb_idx == ZREG) ? '0 : regs[rb_idx];

endmodule

// File: rtl/tpc_decode.sv
module tpc_decode
  import tri_phase_pkg::*;
(
  input  logic [IW-1:0] ir,
  output dec_t          dec
);

  logic [5:0] opc;
  logic [6:0] fn;

  assign opc = ir[31:26];
  assign fn  = ir[11:5];

  always_comb begin
    dec         = '0;
    dec.ra      = ir[25:21];
    dec.rb      = ir[20:16];
    dec.rc      = ir[4:0];
    dec.use_lit = ir[12];
    dec.lit     = ir[20:13];
    dec.disp    = ir[15:0];
    dec.kind    = K_BAD;
    dec.aluop   = ALU_ADD;
    case (opc)
      OPC_INTA: begin
        if (fn == FN_ADD) begin
          dec.kind  = K_OPER;
          dec.aluop = ALU_ADD;
        end else if (fn == FN_S4SUB) begin
          dec.kind  = K_OPER;
          dec.aluop = ALU_S4SUB;
        end
      end
      OPC_SHFT: begin
        if (fn == FN_SLL) begin
          dec.kind  = K_OPER;
          dec.aluop = ALU_SLL;
        end
      end
      OPC_MULT: begin
        if (fn == FN_MUL) begin
          dec.kind  = K_OPER;
          dec.aluop = ALU_MUL;
        end
      end
      OPC_LDQ:  dec.kind = K_LOAD;
      OPC_STQ:  dec.kind = K_STORE;
      OPC_STOP: dec.kind = K_STOP;
      default:  dec.kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/tpc_alu.sv
module tpc_alu
  import tri_phase_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);

  logic [XLEN-1:0] prod;

  assign prod = a * b;

  always_comb begin
    case (op)
      ALU_ADD:   y = a + b;
      ALU_S4SUB: y = (a << 2) - b;
      ALU_SLL:   y = a << b[SHW-1:0];
      ALU_MUL:   y = prod;
      default:   y = '0;
    endcase
  end

endmodule

// File: rtl/tri_phase_core.sv
module tri_phase_core
  import tri_phase_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  parameter longint unsigned RESET_PC = 0,
  localparam int RAW = $clog2(NREG),
  localparam int ALN = $clog2(XLEN / 8)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [IW-1:0]   imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic            dmem_re,
  output logic            dmem_we,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            halted,
  output logic            illegal,
  output logic            misalign
);

  phase_e          st_q;
  logic [XLEN-1:0] pc_q;
  dec_t            dec;
  logic [XLEN-1:0] ra_val, rb_val, b_opnd, alu_y, ea;
  logic            ea_ok;

  logic [XLEN-1:0] res_q;
  logic            wb_en_q;
  logic [RAW-1:0]  wb_idx_q;
  logic            is_ld_q;
  logic            ld_pend_q;
  logic [RAW-1:0]  ld_dst_q;

  logic [XLEN-1:0] dm_addr_q, dm_wdata_q;
  logic            dm_re_q, dm_we_q;
  logic            halt_q, bad_q, mis_q;

  logic            rf_we;
  logic [RAW-1:0]  rf_wa;
  logic [XLEN-1:0] rf_wd;

  tpc_decode u_dec (
    .ir  (imem_rdata),
    .dec (dec)
  );

  tpc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk    (clk),
    .ra_idx (RAW'(dec.ra)),
    .rb_idx (RAW'(dec.rb)),
    .ra_val (ra_val),
    .rb_val (rb_val),
    .wr_en  (rf_we),
    .wr_idx (rf_wa),
    .wr_val (rf_wd)
  );

  assign b_opnd = dec.use_lit ? XLEN'(dec.lit) : rb_val;

  tpc_alu #(.XLEN(XLEN)) u_alu (
    .op (dec.aluop),
    .a  (ra_val),
    .b  (b_opnd),
    .y  (alu_y)
  );

  assign ea    = rb_val + {{(XLEN-16){dec.disp[15]}}, dec.disp};
  assign ea_ok = (ea[ALN-1:0] == '0);

  // Register writes: operate results in update, load data in the next fetch.
  always_comb begin
    if (st_q == ST_FETCH) begin
      rf_we = ld_pend_q;
      rf_wa = ld_dst_q;
      rf_wd = dmem_rdata;
    end else begin
      rf_we = (st_q == ST_UPDATE) && wb_en_q;
      rf_wa = wb_idx_q;
      rf_wd = res_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_FETCH;
      pc_q       <= XLEN'(RESET_PC);
      res_q      <= '0;
      wb_en_q    <= 1'b0;
      wb_idx_q   <= '0;
      is_ld_q    <= 1'b0;
      ld_pend_q  <= 1'b0;
      ld_dst_q   <= '0;
      dm_addr_q  <= '0;
      dm_wdata_q <= '0;
      dm_re_q    <= 1'b0;
      dm_we_q    <= 1'b0;
      halt_q     <= 1'b0;
      bad_q      <= 1'b0;
      mis_q      <= 1'b0;
    end else begin
      case (st_q)
        ST_FETCH: begin
          ld_pend_q <= 1'b0;
          st_q      <= ST_EXEC;
        end
        ST_EXEC: begin
          res_q    <= alu_y;
          wb_idx_q <= RAW'(dec.rc);
          ld_dst_q <= RAW'(dec.ra);
          wb_en_q  <= (dec.kind == K_OPER);
          is_ld_q  <= (dec.kind == K_LOAD);
          case (dec.kind)
            K_OPER: st_q <= ST_UPDATE;
            K_LOAD, K_STORE: begin
              if (ea_ok) begin
                dm_addr_q  <= ea;
                dm_wdata_q <= ra_val;
                dm_re_q    <= (dec.kind == K_LOAD);
                dm_we_q    <= (dec.kind == K_STORE);
                st_q       <= ST_UPDATE;
              end else begin
                mis_q  <= 1'b1;
                halt_q <= 1'b1;
                st_q   <= ST_HALT;
              end
            end
            K_STOP: begin
              halt_q <= 1'b1;
              st_q   <= ST_HALT;
            end
            default: begin
              bad_q  <= 1'b1;
              halt_q <= 1'b1;
              st_q   <= ST_HALT;
            end
          endcase
        end
        ST_UPDATE: begin
          dm_re_q   <= 1'b0;
          dm_we_q   <= 1'b0;
          wb_en_q   <= 1'b0;
          ld_pend_q <= is_ld_q;
          pc_q      <= pc_q + XLEN'(4);
          st_q      <= ST_FETCH;
        end
        default: st_q <= ST_HALT;
      endcase
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = dm_addr_q;
  assign dmem_wdata = dm_wdata_q;
  assign dmem_re    = dm_re_q;
  assign dmem_we    = dm_we_q;
  assign halted     = halt_q;
  assign illegal    = bad_q;
  assign misalign   = mis_q;

  // R7
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we && dmem_re));

  // R9
  mem_align_chk: assert property (@(posedge clk) disable iff (rst)
    (dmem_we || dmem_re) |-> (dmem_addr[ALN-1:0] == '0));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(imem_addr) |-> (imem_addr == $past(imem_addr) + XLEN'(4)));

  // R11
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(imem_addr) && !dmem_we && !dmem_re));

  // R10
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |=> (illegal && halted));

endmodule

// File: tb/tri_phase_core_tb_top.sv
module tri_phase_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] imem_addr;
  logic [31:0] imem_rdata = '0;
  logic [63:0] dmem_addr;
  logic        dmem_re, dmem_we;
  logic [63:0] dmem_wdata;
  logic [63:0] dmem_rdata = '0;
  logic        halted, illegal, misalign;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [31:0] STOPW = 32'h6bfa8001;

  logic [31:0] imem [64];
  logic [63:0] dmem [64];

  logic [63:0] exp_addr [$];
  logic [63:0] exp_data [$];
  string       exp_tag  [$];

  always #10 clk = ~clk;

  tri_phase_core dut_i (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_re    (dmem_re),
    .dmem_we    (dmem_we),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata),
    .halted     (halted),
    .illegal    (illegal),
    .misalign   (misalign)
  );

  // Synchronous memory models.
  always @(posedge clk) begin
    imem_rdata <= imem[imem_addr[7:2]];
    if (dmem_re) dmem_rdata <= dmem[dmem_addr[8:3]];
    if (dmem_we) dmem[dmem_addr[8:3]] <= dmem_wdata;
  end

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compare every store against the scoreboard.
  always @(negedge clk) begin
    if (!rst && dmem_we) begin
      if (exp_addr.size() == 0) begin
        n_chk++;
        n_bad++;
        $display("FAIL unexpected store: actual addr %h data %h expected none", dmem_addr, dmem_wdata);
      end else begin
        automatic string       t = exp_tag.pop_front();
        automatic logic [63:0] a = exp_addr.pop_front();
        automatic logic [63:0] d = exp_data.pop_front();
        check64({t, " store addr"}, dmem_addr, a);
        check64({t, " store data"}, dmem_wdata, d);
      end
    end
  end

  task automatic expect_store(input string tag, input logic [63:0] a, input logic [63:0] d);
    exp_tag.push_back(tag);
    exp_addr.push_back(a);
    exp_data.push_back(d);
  endtask

  function automatic logic [31:0] enc_rr(logic [5:0] op, logic [4:0] ra, logic [4:0] rb,
                                         logic [6:0] fn, logic [4:0] rc);
    return {op, ra, rb, 3'b000, 1'b0, fn, rc};
  endfunction

  function automatic logic [31:0] enc_ri(logic [5:0] op, logic [4:0] ra, logic [7:0] lit,
                                         logic [6:0] fn, logic [4:0] rc);
    return {op, ra, lit, 1'b1, fn, rc};
  endfunction

  function automatic logic [31:0] enc_m(logic [5:0] op, logic [4:0] ra, logic [4:0] rb,
                                        logic [15:0] disp);
    return {op, ra, rb, disp};
  endfunction

  function automatic logic [31:0] ldq(logic [4:0] ra, logic [4:0] rb, logic [15:0] d);
    return enc_m(6'h29, ra, rb, d);
  endfunction

  function automatic logic [31:0] stq(logic [4:0] ra, logic [4:0] rb, logic [15:0] d);
    return enc_m(6'h2D, ra, rb, d);
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin
      imem[i] = STOPW;
      dmem[i] = '0;
    end
  endtask

  task automatic run_prog(input string tag, output int cyc);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 3000) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    n_chk++;
    if (!halted) begin
      n_bad++;
      $display("FAIL %s watchdog: actual running expected halted", tag);
    end
    repeat (2) @(negedge clk);
    check64({tag, " pending stores"}, 64'(exp_addr.size()), 64'd0);
    exp_addr.delete();
    exp_data.delete();
    exp_tag.delete();
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL global watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int          cyc;
    logic [63:0] x, y, z, a, b, p, q;

    // R1 reset state
    clear_mem();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check64("R1 halted", 64'(halted), 0);
    check64("R1 illegal", 64'(illegal), 0);
    check64("R1 misalign", 64'(misalign), 0);
    check64("R1 strobes", 64'({dmem_we, dmem_re}), 0);
    check64("R1 pc", imem_addr, 0);

    // R12 sequence, two operand sets
    for (int s = 0; s < 2; s++) begin
      clear_mem();
      x = (s == 0) ? 64'd5 : 64'h1234_5678_9abc_def0;
      y = (s == 0) ? 64'd7 : 64'hfedc_ba98_7654_3211;
      z = (s == 0) ? 64'd11 : 64'h0f0f_0f0f_0f0f_0f0f;
      dmem[0] = x; dmem[1] = y; dmem[2] = z;
      imem[0] = ldq(16, 31, 0);
      imem[1] = ldq(17, 31, 8);
      imem[2] = ldq(18, 31, 16);
      imem[3] = 32'h42110401;
      imem[4] = 32'h42410400;
      imem[5] = 32'h42009410;
      imem[6] = 32'h42310571;
      imem[7] = 32'h4a209731;
      imem[8] = 32'h42110410;
      imem[9] = 32'h4c100400;
      imem[10] = stq(0, 31, 24);
      imem[11] = STOPW;
      expect_store("R12 arith", 64'd24, (x + y + z) * ((x + 64'd4) + 64'd48 * y));
      run_prog("R12", cyc);
    end

    // R3 R4 R5 operate forms
    clear_mem();
    a = 64'h8000_0000_0000_0003;
    b = 64'd65;
    dmem[0] = a; dmem[1] = b;
    imem[0]  = ldq(1, 31, 0);
    imem[1]  = ldq(2, 31, 8);
    imem[2]  = enc_rr(6'h10, 1, 2, 7'h20, 3);
    imem[3]  = stq(3, 31, 64);
    imem[4]  = enc_rr(6'h10, 1, 2, 7'h2B, 4);
    imem[5]  = stq(4, 31, 72);
    imem[6]  = enc_rr(6'h12, 1, 2, 7'h39, 5);
    imem[7]  = stq(5, 31, 80);
    imem[8]  = enc_rr(6'h13, 1, 1, 7'h20, 6);
    imem[9]  = stq(6, 31, 88);
    imem[10] = enc_ri(6'h10, 1, 8'hFF, 7'h20, 7);
    imem[11] = stq(7, 31, 96);
    imem[12] = enc_ri(6'h12, 2, 8'd3, 7'h39, 8);
    imem[13] = stq(8, 31, 104);
    expect_store("R3 add", 64'd64, a + b);
    expect_store("R3 s4sub", 64'd72, (a << 2) - b);
    expect_store("R4 sll low6", 64'd80, a << 1);
    expect_store("R3 mul low64", 64'd88, a * a);
    expect_store("R5 literal add", 64'd96, a + 64'd255);
    expect_store("R5 literal sll", 64'd104, b << 3);
    run_prog("R3", cyc);

    // R6 register 31
    clear_mem();
    dmem[0] = 64'hdead_beef;
    imem[0] = enc_ri(6'h10, 31, 8'd9, 7'h20, 31);
    imem[1] = stq(31, 31, 8);
    imem[2] = enc_ri(6'h10, 31, 8'd5, 7'h20, 9);
    imem[3] = stq(9, 31, 16);
    imem[4] = ldq(31, 31, 0);
    imem[5] = stq(31, 31, 24);
    expect_store("R6 op to r31", 64'd8, 64'd0);
    expect_store("R6 r31 reads zero", 64'd16, 64'd5);
    expect_store("R6 load to r31", 64'd24, 64'd0);
    run_prog("R6", cyc);

    // R7 R8 load-use, negative displacement, swap
    clear_mem();
    p = 64'h0123_4567_89ab_cdef;
    q = 64'hfeed_face_cafe_f00d;
    dmem[2] = 64'h40;
    dmem[7] = 64'habcd;
    dmem[16] = p;
    dmem[17] = q;
    imem[0] = ldq(1, 31, 16);
    imem[1] = ldq(2, 1, 16'hFFF8);
    imem[2] = enc_ri(6'h10, 2, 8'd1, 7'h20, 3);
    imem[3] = stq(3, 1, 16'hFFF0);
    imem[4] = enc_ri(6'h10, 31, 8'h80, 7'h20, 16);
    imem[5] = enc_ri(6'h10, 31, 8'h88, 7'h20, 17);
    imem[6] = ldq(1, 16, 0);
    imem[7] = ldq(2, 17, 0);
    imem[8] = stq(2, 16, 0);
    imem[9] = stq(1, 17, 0);
    expect_store("R8 load-use neg disp", 64'h30, 64'habce);
    expect_store("R7 swap first", 64'h80, q);
    expect_store("R7 swap second", 64'h88, p);
    run_prog("R7", cyc);

    // R9 misaligned store
    clear_mem();
    imem[0] = enc_ri(6'h10, 31, 8'd4, 7'h20, 1);
    imem[1] = stq(1, 1, 0);
    imem[2] = stq(31, 31, 0);
    run_prog("R9", cyc);
    check64("R9 misalign flag", 64'(misalign), 1);
    check64("R9 illegal clear", 64'(illegal), 0);

    // R1 reset clears the flags of a stopped core
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check64("R1 flags after stop", 64'({halted, illegal, misalign}), 0);
    check64("R1 pc after stop", imem_addr, 0);

    // R10 unknown opcode and unknown function
    clear_mem();
    imem[0] = 32'hFC00_0000;
    imem[1] = stq(31, 31, 0);
    run_prog("R10 opcode", cyc);
    check64("R10 illegal opcode", 64'({illegal, misalign}), 64'b10);
    clear_mem();
    imem[0] = enc_rr(6'h10, 1, 2, 7'h7F, 3);
    imem[1] = stq(31, 31, 0);
    run_prog("R10 function", cyc);
    check64("R10 illegal function", 64'({illegal, misalign}), 64'b10);

    // R11 R2 stop and timing
    clear_mem();
    imem[0] = enc_ri(6'h10, 31, 8'd1, 7'h20, 1);
    imem[1] = enc_ri(6'h10, 31, 8'd2, 7'h20, 2);
    imem[2] = STOPW;
    run_prog("R11", cyc);
    check64("R2 cycles to halt", 64'(cyc), 64'd8);
    check64("R11 flags", 64'({halted, illegal, misalign}), 64'b100);
    check64("R11 pc holds", imem_addr, 64'd8);
    repeat (5) @(negedge clk);
    check64("R11 pc still held", imem_addr, 64'd8);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule